// File: doc/BRIEF.md
# Dual-Stage Watchdog Timer

This block is a countdown timer with a small word-addressed register interface, used as a two-stage watchdog. Software writes a soft-stage count into the load register and enables the timer through the control register. To keep the system alive, software kicks the timer before the count reaches zero. A kick is a fixed sequence: clear any pending interrupt, hold the timer, rewrite the load value, and re-enable.

If the soft stage runs out, the block raises an interrupt. It then reloads itself with a hard-stage count and keeps counting. The hard count is fixed at elaboration as the margin in seconds times the timer clock rate. If the hard stage also runs out without a kick, the block drives a system reset pulse of fixed length. After the pulse the counter stays stopped until software writes control again.

The soft count software loads is normally (total period − margin) × timer rate. The margin may be 1 to 160 s and the total period 1 to 170 s. A registered stage flag tells which stage is counting.

Top module: `wdt_dual_stage`

## Requirements
- R1: After reset `irq_o`, `sys_rst_o` and `stage_o` are 0, and the control, current value and status registers read 0.
- R2: The registers are 32-bit words at byte offsets 0x00 (load, read/write), 0x04 (current value, read-only), 0x08 (control), 0x0C (interrupt clear) and 0x10 (interrupt status). The load register reads back the full value written. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R3: Control bit 0 runs the counter and bit 1 arms the watchdog. Any control write with bit 0 set copies the load register into the count and clears `stage_o`. While running, the count drops by one each cycle.
- R4: With control value 0 (stopped) or 2 (held), the count does not change, even while the load register is rewritten.
- R5: When armed and running, the count reaches zero. One cycle later `irq_o` and `stage_o` go to 1 and the count reloads with HARD = MARGIN_S × TIMER_HZ. With load N, `irq_o` is 1 exactly N+1 cycles after the enabling write.
- R6: The status register reads 1 while an interrupt is pending. A read of the clear register at 0x0C drops `irq_o` on the next cycle.
- R7: When the hard stage reaches zero, `sys_rst_o` rises one cycle later and stays high for exactly RST_CYCLES cycles. Control then reads 0 and the count stays at 0.
- R8: A kick (clear read, control 2, load write, control 3) returns `stage_o` to 0 from either stage. Repeating kicks within the soft count keeps `irq_o` and `sys_rst_o` low.
- R9: When running unarmed (control value 1), reaching zero is ignored: no interrupt, no reload, no stage change and no reset, and the count stays 0.
- R10: Writes to the current value register at 0x04 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Soft-stage expiry interrupt, pending until cleared |
| stage_o | output | 1 | Counting stage: 0 soft, 1 hard |
| sys_rst_o | output | 1 | System reset pulse after hard-stage expiry |

## Verification
The countdown is tried from a fresh enable, from a freeze by the stopped and held control values, and across an unattended run that goes through both stages. The exact cycle on which `irq_o` and `sys_rst_o` rise shows whether the reload count and the zero detection are off by one. A run with repeated kicks, and a single kick issued in the hard stage, separate a working refresh path from one that only clears the interrupt. A run with control value 1 shows that expiry handling depends on the arm bit and not on counting alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Word index of each register (byte address bits [ADDR_W-1:2]).
  typedef enum logic [2:0] {
    REG_LOAD   = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_EOI    = 3'd3,
    REG_STATUS = 3'd4
  } wdt_reg_e;

  localparam int CTRL_W       = 2;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_ARM_BIT = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] count_i,
  input  logic              soft_exp_i,
  input  logic              hard_exp_i,
  output logic [DATA_W-1:0] load_o,
  output logic              run_o,
  output logic              arm_o,
  output logic              load_pulse_o,
  output logic              eoi_rd_o,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [DATA_W-1:0] load_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              irq_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic [IDX_W-1:0]  word_idx;
  logic              aligned;
  logic              wr_load, wr_ctrl;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_load  = bus_wr & aligned & (word_idx == IDX_W'(REG_LOAD));
  assign wr_ctrl  = bus_wr & aligned & (word_idx == IDX_W'(REG_CTRL));
  assign eoi_rd_o = bus_rd & aligned & (word_idx == IDX_W'(REG_EOI));
  assign load_pulse_o = wr_ctrl & bus_wdata[CTRL_RUN_BIT];

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (word_idx)
        IDX_W'(REG_LOAD):   rd_mux = load_q;
        IDX_W'(REG_COUNT):  rd_mux = count_i;
        IDX_W'(REG_CTRL):   rd_mux = DATA_W'(ctrl_q);
        IDX_W'(REG_STATUS): rd_mux = DATA_W'(irq_q);
        default:            rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_load) load_q <= bus_wdata;
      // A software write to control wins over the hard-expiry stop.
      if (wr_ctrl)         ctrl_q <= bus_wdata[CTRL_W-1:0];
      else if (hard_exp_i) ctrl_q <= '0;
      // A new expiry wins over a clear in the same cycle.
      if (soft_exp_i)    irq_q <= 1'b1;
      else if (eoi_rd_o) irq_q <= 1'b0;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign load_o    = load_q;
  assign run_o     = ctrl_q[CTRL_RUN_BIT];
  assign arm_o     = ctrl_q[CTRL_ARM_BIT];
  assign irq_o     = irq_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W      = 32,
  parameter int HARD_COUNT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_pulse_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             arm_i,
  output logic [CNT_W-1:0] count_o,
  output logic             stage_o,
  output logic             soft_exp_o,
  output logic             hard_exp_o
);
  logic [CNT_W-1:0] count_q;
  logic             stage_q;
  logic             at_zero;
  logic             expire;

  assign at_zero    = (count_q == '0);
  assign expire     = run_i & arm_i & at_zero & ~load_pulse_i;
  assign soft_exp_o = expire & ~stage_q;
  assign hard_exp_o = expire & stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      stage_q <= 1'b0;
    end else if (load_pulse_i) begin
      count_q <= load_val_i;
      stage_q <= 1'b0;
    end else if (run_i) begin
      if (!at_zero) begin
        count_q <= count_q - 1'b1;
      end else if (soft_exp_o) begin
        count_q <= CNT_W'(HARD_COUNT);
        stage_q <= 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign stage_o = stage_q;
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] left_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else if (fire_i) begin
      pulse_q <= 1'b1;
      left_q  <= CW'(PULSE_CYCLES - 1);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/wdt_dual_stage.sv
module wdt_dual_stage #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter int TIMER_HZ   = 4,
  parameter int MARGIN_S   = 2,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              stage_o,
  output logic              sys_rst_o
);
  localparam int HARD_COUNT = MARGIN_S * TIMER_HZ;

  if (MARGIN_S < 1 || MARGIN_S > 160) begin : g_bad_margin
    $error("MARGIN_S must lie between 1 and 160 seconds");
  end

  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] count;
  logic run, arm, load_pulse, eoi_rd;
  logic soft_exp, hard_exp;

  wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_i(count), .soft_exp_i(soft_exp), .hard_exp_i(hard_exp),
    .load_o(load_val), .run_o(run), .arm_o(arm),
    .load_pulse_o(load_pulse), .eoi_rd_o(eoi_rd), .irq_o(irq_o)
  );

  wdt_counter #(.CNT_W(DATA_W), .HARD_COUNT(HARD_COUNT)) u_cnt (
    .clk(clk), .rst(rst),
    .load_pulse_i(load_pulse), .load_val_i(load_val),
    .run_i(run), .arm_i(arm),
    .count_o(count), .stage_o(stage_o),
    .soft_exp_o(soft_exp), .hard_exp_o(hard_exp)
  );

  wdt_rst_pulse #(.PULSE_CYCLES(RST_CYCLES)) u_rstp (
    .clk(clk), .rst(rst), .fire_i(hard_exp), .pulse_o(sys_rst_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              arm,
  input logic              load_pulse,
  input logic [DATA_W-1:0] count,
  input logic              stage,
  input logic              irq,
  input logic              sys_rst,
  input logic              eoi_rd,
  input logic              soft_exp
);
  localparam int HW = $clog2(RST_CYCLES + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= '0;
    else if (sys_rst) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
    (run && count != '0 && !load_pulse) |=> count == $past(count) - 1'b1);

  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_pulse) |=> $stable(count));

  p_irq_with_stage_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> stage);

  p_eoi_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (eoi_rd && !soft_exp) |=> !irq);

  p_rst_from_hard_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst) |-> (stage && !run));

  p_rst_max_width_r7: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> hi_cnt < HW'(RST_CYCLES));

  p_rst_exact_width_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> hi_cnt == HW'(RST_CYCLES));

  p_unarmed_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!arm && !load_pulse) |=> (!$rose(irq) && !$rose(stage)));
endmodule

bind wdt_dual_stage wdt_checker #(.DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .run(run), .arm(arm), .load_pulse(load_pulse),
  .count(count), .stage(stage_o), .irq(irq_o), .sys_rst(sys_rst_o),
  .eoi_rd(eoi_rd), .soft_exp(soft_exp)
);

// File: tb/wdt_dual_stage_tb_top.sv
module wdt_dual_stage_tb_top;
  localparam int HZ     = 4;
  localparam int MARGIN = 2;
  localparam int PERIOD = 5;
  localparam int PULSE  = 16;
  localparam int HARD   = MARGIN * HZ;            // 8
  localparam int SOFT   = (PERIOD - MARGIN) * HZ; // 12

  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08,
                         A_EOI = 5'h0C, A_STAT = 5'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, stage_o, sys_rst_o;
  int          n_checks = 0, n_err = 0;

  always #5 clk = ~clk;

  wdt_dual_stage #(.TIMER_HZ(HZ), .MARGIN_S(MARGIN), .RST_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .stage_o(stage_o), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end just after a falling edge.
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    logic [31:0] d;
    bus_read(A_EOI, d);
    bus_write(A_CTRL, 32'd2);
    bus_write(A_LOAD, SOFT);
    bus_write(A_CTRL, 32'd3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 stage", {31'b0, stage_o}, 0);
    chk("R1 sys_rst", {31'b0, sys_rst_o}, 0);
    bus_read(A_CTRL, d); chk("R1 ctrl", d, 0);
    bus_read(A_CNT, d);  chk("R1 count", d, 0);
    bus_read(A_STAT, d); chk("R1 status", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(A_LOAD, 32'hA5A5_1234);
    bus_read(A_LOAD, d); chk("R2 load readback", d, 32'hA5A5_1234);
    bus_write(A_LOAD, 32'h5A5A_EDCB);
    bus_read(A_LOAD, d); chk("R2 load readback", d, 32'h5A5A_EDCB);
    bus_write(A_CNT, 32'h0000_FFFF);
    bus_read(A_CNT, d); chk("R10 count write ignored", d, 0);
  endtask

  task automatic t_count_hold();
    logic [31:0] d;
    bus_write(A_LOAD, SOFT);
    bus_write(A_CTRL, 32'd3);
    bus_read(A_CNT, d); chk("R3 loaded count", d, SOFT);
    bus_read(A_CNT, d); chk("R3 decrement", d, SOFT - 1);
    bus_write(A_CTRL, 32'd2);
    bus_read(A_CNT, d); chk("R4 held count", d, SOFT - 3);
    bus_write(A_LOAD, 32'd99);
    bus_read(A_CNT, d); chk("R4 load while held", d, SOFT - 3);
    bus_write(A_CNT, 32'd7);
    bus_read(A_CNT, d); chk("R10 count write while held", d, SOFT - 3);
    bus_write(A_CTRL, 32'd0);
    idle(3);
    bus_read(A_CNT, d); chk("R4 stopped count", d, SOFT - 3);
  endtask

  task automatic t_two_stage();
    logic [31:0] d;
    bus_write(A_LOAD, SOFT);
    bus_write(A_CTRL, 32'd3);
    idle(SOFT);
    chk("R5 irq before expiry", {31'b0, irq_o}, 0);
    chk("R5 stage before expiry", {31'b0, stage_o}, 0);
    idle(1);
    chk("R5 irq at expiry", {31'b0, irq_o}, 1);
    chk("R5 stage at expiry", {31'b0, stage_o}, 1);
    bus_read(A_CNT, d); chk("R5 hard reload", d, HARD);
    bus_read(A_STAT, d); chk("R6 status pending", d, 1);
    idle(HARD - 2);
    chk("R7 no reset yet", {31'b0, sys_rst_o}, 0);
    idle(1);
    chk("R7 reset rises", {31'b0, sys_rst_o}, 1);
    idle(PULSE - 1);
    chk("R7 reset last cycle", {31'b0, sys_rst_o}, 1);
    idle(1);
    chk("R7 reset ends", {31'b0, sys_rst_o}, 0);
    bus_read(A_CTRL, d); chk("R7 ctrl stopped", d, 0);
    idle(4);
    bus_read(A_CNT, d); chk("R7 count parked", d, 0);
    bus_read(A_EOI, d);
    chk("R6 irq cleared", {31'b0, irq_o}, 0);
    bus_read(A_STAT, d); chk("R6 status cleared", d, 0);
  endtask

  task automatic t_kick();
    bus_write(A_LOAD, SOFT);
    bus_write(A_CTRL, 32'd3);
    for (int i = 0; i < 4; i++) begin
      idle(SOFT - 4);
      kick();
      chk("R8 kick irq", {31'b0, irq_o}, 0);
      chk("R8 kick stage", {31'b0, stage_o}, 0);
      chk("R8 kick reset", {31'b0, sys_rst_o}, 0);
    end
    idle(SOFT + 1);
    chk("R8 expired for hard kick", {31'b0, stage_o}, 1);
    kick();
    chk("R8 hard-stage kick stage", {31'b0, stage_o}, 0);
    chk("R8 hard-stage kick irq", {31'b0, irq_o}, 0);
    idle(SOFT - 2);
    chk("R8 no reset after kick", {31'b0, sys_rst_o}, 0);
    bus_write(A_CTRL, 32'd0);
  endtask

  task automatic t_unarmed();
    logic [31:0] d;
    bus_write(A_LOAD, 32'd5);
    bus_write(A_CTRL, 32'd1);
    idle(12);
    chk("R9 no irq", {31'b0, irq_o}, 0);
    chk("R9 no stage", {31'b0, stage_o}, 0);
    chk("R9 no reset", {31'b0, sys_rst_o}, 0);
    bus_read(A_CNT, d); chk("R9 count stays zero", d, 0);
    bus_write(A_CTRL, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_count_hold();
    t_two_stage();
    t_kick();
    t_unarmed();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule